// File: doc/BRIEF.md
# Single-Channel DMA Transfer Controller

This block is one DMA channel that moves words between memory and a peripheral, or from one memory block to another, without the processor taking part. Software programs it through a small register port selected by a chip-select and a register-select input. The registers hold a source address, a destination address (used only for memory-to-memory), a word count and a control word. Writing the control word with its start bit set arms the channel. A status register reports whether the channel is busy and whether a transfer has reached its end.

Once armed, the channel waits for an unmasked request. The request is either the peripheral's request line at its programmed active level or a software request bit. The channel then raises its hold request and waits for the processor's hold acknowledge. Only after that acknowledge does it take the bus. Bus ownership is shown by an ownership flag, and the memory lines stay quiet while the flag is low.

Peripheral transfers move one word per bus tenure. Each word takes an address cycle and then a strobe cycle, with the acknowledge to the peripheral held active for both cycles. A memory-to-memory block runs in a single tenure as read/write pairs through an internal holding register. In fill mode the source word is read only once and written to every destination location. A transfer ends when the count reaches zero or when the external end-of-process input is seen. At that point the terminal-count output pulses and the bus is given back.

States and transitions of the controller:
- IDLE → ARMED: an accepted start.
- ARMED → HOLD: an unmasked request.
- HOLD → ADDR: hold acknowledge in a peripheral mode.
- HOLD → MRD: hold acknowledge in memory-to-memory mode.
- ADDR → XFER: always, after one cycle.
- XFER → REL: always, after one cycle.
- MRD → MWR: always, after one cycle.
- MWR → REL: the last word.
- MWR → MWR: more words in fill mode.
- MWR → MRD: more words in copy mode.
- REL → IDLE: hold acknowledge has dropped and the transfer is finished.
- REL → ARMED: hold acknowledge has dropped and words remain.

Top module: `dma_channel`

## Requirements
- R1: After reset, the following outputs are all low, and the status register reads 0:
  - hold_req, bus_own and tc_out;
  - mem_rd, mem_wr and mem_addr;
  - dack.
- R2: Registers are chosen by cpu_rs. Writes take effect when cpu_sel and cpu_we are both high. Reads appear on cpu_rdata, combinationally, while cpu_sel is high. The register codes are:
  - 0 = source/peripheral address;
  - 1 = word count;
  - 2 = control;
  - 3 = status (bit0 busy, bit1 done);
  - 4 = destination address.
- R3: Control register bit fields:
  - bit0 = start (write-only, reads 0);
  - bit1 = I/O-to-memory;
  - bit2 = memory-to-memory;
  - bit3 = count address down;
  - bit4 = fill;
  - bit5 = request active-low;
  - bit6 = acknowledge active-low;
  - bit7 = mask;
  - bit8 = software request.

  An armed channel raises hold_req only while the mask bit is clear and either dreq is at its active level or the software request bit is set.
- R4: bus_own, the memory strobes and a non-zero mem_addr appear only after hold_ack has been seen high. The first owned cycle follows the clock edge at which hold_ack is sampled high.
- R5: Each peripheral word is an address cycle followed by a strobe cycle, with dack active in both.
  - I/O-to-memory: mem_wr is high and mem_wdata carries io_din.
  - Memory-to-I/O: mem_rd is high and io_dout carries mem_rdata.

  mem_rd and mem_wr are never high together.
- R6: After each word, every address register in use changes by one: it counts down when bit3 is set and up otherwise.
- R7: After each word, the count drops by one. The word that brings it to zero is the last word. tc_out is high for exactly the one final strobe cycle. After that the done bit is set, the software request bit is cleared, and busy falls once the bus is released.
- R8: In the peripheral modes, hold_req drops after every word, so each word has its own bus tenure. A memory-to-memory block uses a single tenure. hold_req is low in the cycle after tc_out.
- R9: If eop_in is high in any owned cycle of a word, that word is the last. The count keeps the words not yet moved.
- R10: dack idles at the level given by bit6 and is active at the opposite level. It is active only while the bus is owned. dreq is treated as active low when bit5 is set.
- R11: Memory-to-memory copy reads the source, then writes the destination, once per word.
- R12: In fill mode, the source is read once and the same word is written to every destination location. Locations past the end of the block are left alone.
- R13: While busy, writes to the address and count registers are ignored, and so is the start bit. A start with a word count of 0 leaves the channel idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Chip select for the register port |
| cpu_rs | input | 3 | Register select |
| cpu_we | input | 1 | Write enable for the register port |
| cpu_wdata | input | DW | Register write data |
| cpu_rdata | output | DW | Register read data |
| hold_req | output | 1 | Bus hold request to the processor |
| hold_ack | input | 1 | Hold acknowledge from the processor |
| dreq | input | 1 | Peripheral request, programmable polarity |
| dack | output | 1 | Peripheral acknowledge, programmable polarity |
| eop_in | input | 1 | External end-of-process |
| tc_out | output | 1 | Terminal-count pulse |
| bus_own | output | 1 | Controller owns the bus |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid in the strobe cycle |
| io_din | input | DW | Peripheral data toward memory |
| io_dout | output | DW | Memory data toward the peripheral |

## Verification
The assertions check, on every cycle, the properties that can be judged locally:
- ownership only ever follows an acknowledge;
- a hold request only ever follows an unmasked request;
- the acknowledge is never active off the bus;
- the two strobes never overlap;
- the count only ever steps down by one while busy;
- the terminal-count pulse lasts one cycle and is followed by release.

The bench scenarios are needed for the properties that only show over whole transfers:
- the data that lands in memory or reaches the peripheral, and the direction of address stepping;
- the number of bus tenures, and the single source read in fill mode;
- where an early end-of-process leaves the count;
- writes ignored while busy;
- starts with a zero count.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ARMED, ST_HOLD, ST_ADDR, ST_XFER, ST_MRD, ST_MWR, ST_REL
    } dma_state_t;

    localparam logic [2:0] RS_SRC  = 3'd0;
    localparam logic [2:0] RS_CNT  = 3'd1;
    localparam logic [2:0] RS_CTRL = 3'd2;
    localparam logic [2:0] RS_STAT = 3'd3;
    localparam logic [2:0] RS_DST  = 3'd4;

    localparam int CB_START = 0;
    localparam int CTRL_LSB = 1;
    localparam int CTRL_MSB = 8;

    // control fields, MSB first: bit8 .. bit1 of the control word
    typedef struct packed {
        logic swreq;
        logic mask;
        logic dack_lo;
        logic dreq_lo;
        logic fill;
        logic down;
        logic m2m;
        logic to_mem;
    } ctrl_t;

endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
    import dmach_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_sel,
    input  logic [2:0]    cpu_rs,
    input  logic          cpu_we,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    input  logic          busy,
    input  logic          tc_event,
    input  logic          word_done,
    input  logic          src_step,
    input  logic          dst_step,
    output ctrl_t         ctrl,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic [CW-1:0] count,
    output logic          start_pulse
);
    localparam logic [AW-1:0] A_ONE = AW'(1);
    localparam logic [CW-1:0] C_ONE = CW'(1);

    logic wr;
    logic done_q;

    assign wr          = cpu_sel && cpu_we;
    assign start_pulse = wr && (cpu_rs == RS_CTRL) && cpu_wdata[CB_START]
                         && !busy && (count != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_addr <= '0;
            dst_addr <= '0;
            count    <= '0;
            ctrl     <= '0;
            done_q   <= 1'b0;
        end else begin
            if (wr && !busy && cpu_rs == RS_SRC)
                src_addr <= cpu_wdata[AW-1:0];
            else if (src_step)
                src_addr <= ctrl.down ? src_addr - A_ONE : src_addr + A_ONE;

            if (wr && !busy && cpu_rs == RS_DST)
                dst_addr <= cpu_wdata[AW-1:0];
            else if (dst_step)
                dst_addr <= ctrl.down ? dst_addr - A_ONE : dst_addr + A_ONE;

            if (wr && !busy && cpu_rs == RS_CNT)
                count <= cpu_wdata[CW-1:0];
            else if (word_done)
                count <= count - C_ONE;

            if (wr && cpu_rs == RS_CTRL)
                ctrl <= ctrl_t'(cpu_wdata[CTRL_MSB:CTRL_LSB]);
            else if (tc_event)
                ctrl.swreq <= 1'b0;

            if (start_pulse)
                done_q <= 1'b0;
            else if (tc_event)
                done_q <= 1'b1;
        end
    end

    always_comb begin
        cpu_rdata = '0;
        if (cpu_sel) begin
            unique case (cpu_rs)
                RS_SRC:  cpu_rdata = DW'(src_addr);
                RS_DST:  cpu_rdata = DW'(dst_addr);
                RS_CNT:  cpu_rdata = DW'(count);
                RS_CTRL: cpu_rdata = DW'({ctrl, 1'b0});
                RS_STAT: cpu_rdata = DW'({done_q, busy});
                default: cpu_rdata = '0;
            endcase
        end
    end

    // R7: while busy the count moves only downwards, one step at a time
    a_r7_count_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && count != $past(count)) |-> count == $past(count) - C_ONE);

endmodule

// File: rtl/dmach_fsm.sv
module dmach_fsm
    import dmach_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          to_mem,
    input  logic          m2m,
    input  logic          fill,
    input  logic          dreq_lo,
    input  logic          mask,
    input  logic          swreq,
    input  logic          dreq,
    input  logic          hold_ack,
    input  logic          eop_in,
    input  logic [CW-1:0] count,
    output logic          hold_req,
    output logic          bus_own,
    output logic          dack_act,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          use_dst,
    output logic          latch_data,
    output logic          word_done,
    output logic          src_step,
    output logic          dst_step,
    output logic          tc_event,
    output logic          busy
);
    dma_state_t st, nxt;
    logic done_q, eop_q, go, last;

    assign go   = !mask && ((dreq ^ dreq_lo) || swreq);
    assign last = (count == CW'(1)) || eop_in || eop_q;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:  if (start) nxt = ST_ARMED;
            ST_ARMED: if (go) nxt = ST_HOLD;
            ST_HOLD:  if (hold_ack) nxt = m2m ? ST_MRD : ST_ADDR;
            ST_ADDR:  nxt = ST_XFER;
            ST_XFER:  nxt = ST_REL;
            ST_MRD:   nxt = ST_MWR;
            ST_MWR:   if (last) nxt = ST_REL;
                      else nxt = fill ? ST_MWR : ST_MRD;
            ST_REL:   if (!hold_ack) nxt = done_q ? ST_IDLE : ST_ARMED;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            done_q <= 1'b0;
            eop_q  <= 1'b0;
        end else begin
            st <= nxt;
            if (start) begin
                done_q <= 1'b0;
                eop_q  <= 1'b0;
            end else begin
                if (tc_event) done_q <= 1'b1;
                if (bus_own && eop_in) eop_q <= 1'b1;
            end
        end
    end

    always_comb begin
        hold_req   = 1'b0;
        bus_own    = 1'b0;
        dack_act   = 1'b0;
        mem_rd     = 1'b0;
        mem_wr     = 1'b0;
        use_dst    = 1'b0;
        latch_data = 1'b0;
        word_done  = 1'b0;
        src_step   = 1'b0;
        dst_step   = 1'b0;
        unique case (st)
            ST_HOLD: hold_req = 1'b1;
            ST_ADDR: begin
                hold_req = 1'b1; bus_own = 1'b1; dack_act = 1'b1;
            end
            ST_XFER: begin
                hold_req = 1'b1; bus_own = 1'b1; dack_act = 1'b1;
                mem_rd = !to_mem; mem_wr = to_mem;
                word_done = 1'b1; src_step = 1'b1;
            end
            ST_MRD: begin
                hold_req = 1'b1; bus_own = 1'b1; mem_rd = 1'b1;
                latch_data = 1'b1; src_step = !fill;
            end
            ST_MWR: begin
                hold_req = 1'b1; bus_own = 1'b1; mem_wr = 1'b1;
                use_dst = 1'b1; word_done = 1'b1; dst_step = 1'b1;
            end
            default: ;
        endcase
        tc_event = word_done && last;
        busy     = (st != ST_IDLE);
    end

    // R3: a hold request is only ever raised for an unmasked request
    a_r3_hold_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_req) |-> $past(!mask && ((dreq ^ dreq_lo) || swreq)));
    // R4: the bus is taken only after the acknowledge was sampled
    a_r4_own_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_own) |-> $past(hold_ack));
    // R7: terminal count lasts one cycle
    a_r7_tc_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tc_event |=> !tc_event);
    // R8: the hold request drops right after the last word
    a_r8_release_after_tc: assert property (@(posedge clk) disable iff (!rst_n)
        tc_event |=> !hold_req);

endmodule

// File: rtl/dma_channel.sv
module dma_channel
    import dmach_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_sel,
    input  logic [2:0]    cpu_rs,
    input  logic          cpu_we,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          hold_req,
    input  logic          hold_ack,
    input  logic          dreq,
    output logic          dack,
    input  logic          eop_in,
    output logic          tc_out,
    output logic          bus_own,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] io_din,
    output logic [DW-1:0] io_dout
);
    ctrl_t         ctrl;
    logic [AW-1:0] src_addr, dst_addr;
    logic [CW-1:0] count;
    logic [DW-1:0] data_q;
    logic start_pulse, busy, tc_event, word_done, src_step, dst_step;
    logic dack_act, use_dst, latch_data;

    dmach_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_rs(cpu_rs),
        .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .busy(busy), .tc_event(tc_event), .word_done(word_done),
        .src_step(src_step), .dst_step(dst_step), .ctrl(ctrl),
        .src_addr(src_addr), .dst_addr(dst_addr), .count(count),
        .start_pulse(start_pulse)
    );

    dmach_fsm #(.CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start_pulse),
        .to_mem(ctrl.to_mem), .m2m(ctrl.m2m), .fill(ctrl.fill),
        .dreq_lo(ctrl.dreq_lo), .mask(ctrl.mask), .swreq(ctrl.swreq),
        .dreq(dreq), .hold_ack(hold_ack), .eop_in(eop_in), .count(count),
        .hold_req(hold_req), .bus_own(bus_own), .dack_act(dack_act),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .use_dst(use_dst),
        .latch_data(latch_data), .word_done(word_done),
        .src_step(src_step), .dst_step(dst_step), .tc_event(tc_event),
        .busy(busy)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)          data_q <= '0;
        else if (latch_data) data_q <= mem_rdata;
    end

    assign mem_addr  = !bus_own ? '0 : (use_dst ? dst_addr : src_addr);
    assign mem_wdata = ctrl.m2m ? data_q : io_din;
    assign io_dout   = mem_rdata;
    assign dack      = dack_act ^ ctrl.dack_lo;
    assign tc_out    = tc_event;

    // R10: the peripheral acknowledge is active only while the bus is owned
    a_r10_dack_only_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (dack != ctrl.dack_lo) |-> bus_own);
    // R5: the two memory strobes never overlap
    a_r5_no_strobe_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

endmodule

// File: tb/dma_channel_test.sv
module dma_channel_test;
    localparam int AW = 16, CW = 16, DW = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_sel = 0, cpu_we = 0;
    logic [2:0] cpu_rs = '0;
    logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
    logic hold_req, hold_ack = 0, dreq = 0, dack, eop_in = 0, tc_out, bus_own;
    logic [AW-1:0] mem_addr;
    logic mem_rd, mem_wr;
    logic [DW-1:0] mem_wdata, mem_rdata, io_dout;
    logic [DW-1:0] io_din = 16'h00A0;

    logic [DW-1:0] mem [64];
    logic pl_en = 0;
    logic [5:0] pl_addr = '0;
    logic [DW-1:0] pl_data = '0;
    logic exp_dack_lo = 0;
    logic hold_prev = 0;
    int hold_rises = 0, tc_pulses = 0, rd_cycles = 0, dack_on = 0, log_n = 0;
    logic [DW-1:0] io_log [32];
    int tests = 0, fails = 0;

    always #2 clk = ~clk;

    dma_channel #(.AW(AW), .CW(CW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_rs(cpu_rs),
        .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .hold_req(hold_req), .hold_ack(hold_ack), .dreq(dreq), .dack(dack),
        .eop_in(eop_in), .tc_out(tc_out), .bus_own(bus_own),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .io_din(io_din),
        .io_dout(io_dout)
    );

    assign mem_rdata = mem[mem_addr[5:0]];

    initial for (int i = 0; i < 64; i++) mem[i] = '0;

    // processor, memory and peripheral models
    always @(posedge clk) begin
        hold_ack  <= hold_req;
        hold_prev <= hold_req;
        if (hold_req && !hold_prev) hold_rises <= hold_rises + 1;
        if (tc_out) tc_pulses <= tc_pulses + 1;
        if (mem_rd) rd_cycles <= rd_cycles + 1;
        if (bus_own && (dack != exp_dack_lo)) dack_on <= dack_on + 1;
        if (mem_wr) mem[mem_addr[5:0]] <= mem_wdata;
        else if (pl_en) mem[pl_addr] <= pl_data;
        if (mem_wr && (dack != exp_dack_lo)) io_din <= io_din + 1'b1;
        if (mem_rd && (dack != exp_dack_lo)) begin
            io_log[log_n[4:0]] <= io_dout;
            log_n <= log_n + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [2:0] rs, input logic [DW-1:0] d);
        @(negedge clk);
        cpu_sel = 1; cpu_we = 1; cpu_rs = rs; cpu_wdata = d;
        @(negedge clk);
        cpu_sel = 0; cpu_we = 0;
    endtask

    task automatic cpu_read(input logic [2:0] rs, output logic [DW-1:0] d);
        @(negedge clk);
        cpu_sel = 1; cpu_we = 0; cpu_rs = rs;
        #1 d = cpu_rdata;
        cpu_sel = 0;
    endtask

    task automatic preload(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        pl_en = 1; pl_addr = a[5:0]; pl_data = d;
        @(negedge clk);
        pl_en = 0;
    endtask

    task automatic wait_idle(input string req);
        logic [DW-1:0] s;
        bit ok = 0;
        for (int i = 0; i < 400; i++) begin
            cpu_read(3'd3, s);
            if (!s[0]) begin ok = 1; break; end
        end
        chk({req, " transfer finishes"}, ok, 1);
    endtask

    task automatic t_reset();
        logic [DW-1:0] s;
        @(negedge clk);
        chk("R1 outputs", {hold_req, bus_own, tc_out, mem_rd, mem_wr, dack}, 0);
        chk("R1 mem_addr", mem_addr, 0);
        cpu_read(3'd3, s);
        chk("R1 status", s, 0);
    endtask

    task automatic t_regs();
        logic [DW-1:0] d;
        cpu_write(3'd0, 16'h0010); cpu_read(3'd0, d); chk("R2 src addr", d, 16'h0010);
        cpu_write(3'd4, 16'h0031); cpu_read(3'd4, d); chk("R2 dst addr", d, 16'h0031);
        cpu_write(3'd1, 16'h0003); cpu_read(3'd1, d); chk("R2 count", d, 3);
        cpu_write(3'd2, 16'h01F8); cpu_read(3'd2, d); chk("R2 control", d, 16'h01F8);
        cpu_read(3'd3, d); chk("R2 status not armed", d, 0);
        cpu_write(3'd2, 16'h0000);
    endtask

    // mask holds off the request, then an I/O-to-memory block
    task automatic t_mask_io_to_mem();
        logic [DW-1:0] d, base;
        int h0, t0;
        base = io_din; h0 = hold_rises; t0 = tc_pulses;
        cpu_write(3'd0, 16'd8); cpu_write(3'd1, 16'd3);
        dreq = 1;
        cpu_write(3'd2, 16'h0083);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R3 masked request holds off", hold_req, 0);
        end
        cpu_write(3'd0, 16'h003F);
        cpu_read(3'd0, d); chk("R13 address write ignored while busy", d, 8);
        cpu_write(3'd2, 16'h0002);
        for (int i = 0; i < 20 && !hold_req; i++) @(negedge clk);
        chk("R3 hold after unmask", hold_req, 1);
        chk("R4 no ownership before ack", {bus_own, mem_rd, mem_wr, dack}, 0);
        chk("R4 address quiet before ack", mem_addr, 0);
        @(negedge clk);
        chk("R4 still waiting on ack edge", bus_own, 0);
        @(negedge clk);
        chk("R5 address cycle", {bus_own, dack, mem_wr}, 3'b110);
        chk("R5 address cycle address", mem_addr, 8);
        @(negedge clk);
        chk("R5 write strobe cycle", {mem_wr, dack}, 2'b11);
        chk("R5 write data from peripheral", mem_wdata, base);
        wait_idle("R7");
        for (int i = 0; i < 3; i++) chk("R5 memory written", mem[8 + i], base + DW'(i));
        chk("R8 one tenure per word", hold_rises - h0, 3);
        chk("R7 one tc pulse", tc_pulses - t0, 1);
        cpu_read(3'd0, d); chk("R6 address counted up", d, 11);
        cpu_read(3'd1, d); chk("R7 count reaches zero", d, 0);
        cpu_read(3'd3, d); chk("R7 done set, busy clear", d, 2);
        chk("R8 bus released", {hold_req, bus_own}, 0);
    endtask

    task automatic t_mem_to_io_down();
        logic [DW-1:0] d;
        int l0;
        for (int i = 17; i <= 20; i++) preload(i, 16'h1100 + DW'(i));
        l0 = log_n;
        cpu_write(3'd0, 16'd20); cpu_write(3'd1, 16'd4);
        cpu_write(3'd2, 16'h0009);
        wait_idle("R6");
        chk("R5 four words to peripheral", log_n - l0, 4);
        for (int i = 0; i < 4; i++)
            chk("R6 descending read order", io_log[(l0 + i) % 32], 16'h1100 + DW'(20 - i));
        cpu_read(3'd0, d); chk("R6 address counted down", d, 16);
    endtask

    task automatic t_polarity();
        logic [DW-1:0] d;
        int a0;
        preload(24, 16'h2424); preload(25, 16'h2525);
        dreq = 1;
        cpu_write(3'd0, 16'd24); cpu_write(3'd1, 16'd2);
        exp_dack_lo = 1;
        cpu_write(3'd2, 16'h0061);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R10 high dreq is inactive when active-low", hold_req, 0);
        end
        chk("R10 dack idles high", dack, 1);
        a0 = dack_on;
        dreq = 0;
        wait_idle("R10");
        chk("R10 dack low for two cycles per word", dack_on - a0, 4);
        chk("R10 dack back to idle level", dack, 1);
        cpu_read(3'd0, d); chk("R10 transfer completed", d, 26);
        cpu_write(3'd2, 16'h0000);
        exp_dack_lo = 0;
    endtask

    task automatic t_eop();
        logic [DW-1:0] d;
        int t0;
        t0 = tc_pulses;
        dreq = 1;
        cpu_write(3'd0, 16'd12); cpu_write(3'd1, 16'd5);
        cpu_write(3'd2, 16'h0003);
        for (int i = 0; i < 50 && !mem_wr; i++) @(negedge clk);
        eop_in = 1;
        #1 chk("R9 tc with end-of-process", tc_out, 1);
        @(negedge clk);
        eop_in = 0;
        wait_idle("R9");
        cpu_read(3'd1, d); chk("R9 count keeps unmoved words", d, 4);
        cpu_read(3'd0, d); chk("R9 address after one word", d, 13);
        chk("R9 second word not written", mem[13], 0);
        chk("R9 single tc pulse", tc_pulses - t0, 1);
        dreq = 0;
    endtask

    task automatic t_m2m_copy();
        logic [DW-1:0] d;
        int h0, r0;
        for (int i = 0; i < 3; i++) preload(32 + i, 16'h3300 + DW'(i));
        h0 = hold_rises; r0 = rd_cycles;
        cpu_write(3'd0, 16'd32); cpu_write(3'd4, 16'd40); cpu_write(3'd1, 16'd3);
        cpu_write(3'd2, 16'h0105);
        wait_idle("R11");
        for (int i = 0; i < 3; i++) chk("R11 block copied", mem[40 + i], 16'h3300 + DW'(i));
        chk("R11 one read per word", rd_cycles - r0, 3);
        chk("R8 single tenure for block", hold_rises - h0, 1);
        cpu_read(3'd0, d); chk("R6 source stepped", d, 35);
        cpu_read(3'd4, d); chk("R6 destination stepped", d, 43);
        cpu_read(3'd2, d); chk("R7 software request cleared", d, 16'h0004);
    endtask

    task automatic t_fill();
        logic [DW-1:0] d;
        int r0;
        preload(36, 16'h5A5A);
        r0 = rd_cycles;
        cpu_write(3'd0, 16'd36); cpu_write(3'd4, 16'd48); cpu_write(3'd1, 16'd4);
        cpu_write(3'd2, 16'h0115);
        wait_idle("R12");
        for (int i = 0; i < 4; i++) chk("R12 fill value", mem[48 + i], 16'h5A5A);
        chk("R12 block end untouched", mem[52], 0);
        chk("R12 source read once", rd_cycles - r0, 1);
        cpu_read(3'd0, d); chk("R12 source not stepped past one", d, 36);
        cpu_read(3'd4, d); chk("R12 destination stepped", d, 52);
    endtask

    task automatic t_zero_count();
        logic [DW-1:0] d;
        dreq = 1;
        cpu_write(3'd1, 16'd0);
        cpu_write(3'd2, 16'h0003);
        for (int i = 0; i < 4; i++) @(negedge clk);
        chk("R13 zero count no hold", hold_req, 0);
        cpu_read(3'd3, d); chk("R13 zero count stays idle", d[0], 0);
        dreq = 0;
    endtask

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_regs();
        t_mask_io_to_mem();
        t_mem_to_io_down();
        t_polarity();
        t_eop();
        t_m2m_copy();
        t_fill();
        t_zero_count();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule